// File: doc/BRIEF.md
# Fault-response checkpoint and trap controller

This block sits beside a processor core and holds a rolling copy of the state needed to resume after an injected fault. Every cycle it records the program counter, the status word and the two words held in the last two pipeline stages. It feeds these values through a short delay chain, so the copy it exposes always trails the live core by a fixed number of cycles. The capture costs no cycle and no instruction while nothing goes wrong.

When an external fault detector raises its alarm, the chain stops at once. The copy it holds was taken before the faulty cycle. The block issues a one-cycle trap request carrying a fixed vector index, which sends the core to a secure handler. It then stays frozen until that handler acts. Through a small word-addressed register port the handler reads the frozen fields and inspects the sticky alarm and double-fault flags. It then either restores the saved program counter and status word into the core with a one-cycle load strobe, or releases the block without loading.

Top module: `fault_ckpt_ctrl`

## Requirements
- R1: During and just after reset the block is armed, the trap request and load strobe are low, the status word at address 0 reads 0 and every snapshot register reads 0.
- R2: While armed with no alarm, a read in cycle n of address 2 (PC), 3 (status word), 4 (older stage word) or 5 (newer stage word) returns the core inputs of cycle n-LAG, zero-extended to the data width (LAG defaults to 2).
- R3: An alarm seen while armed produces, in the next cycle only, a trap request with the trap vector output equal to TRAP_VEC (default 8'h2A). The block is then frozen: status bit 2 is set and alarm flag bit 0 is set.
- R4: Once frozen, the snapshot registers hold the core inputs of cycle A-LAG, where A is the alarm cycle, whatever the core inputs do afterwards.
- R5: An alarm seen while frozen sets the sticky double-fault flag (status bit 1). It raises no trap request and leaves the snapshot unchanged.
- R6: Writing bit 0 (restore) of the command register at address 1 while frozen gives, in the next cycle, a one-cycle load strobe with the load PC and status outputs equal to the snapshot. The block returns to armed.
- R7: Writing bit 1 (release) of the command register while frozen, with bit 0 clear, returns the block to armed with no load strobe.
- R8: Command writes while armed are ignored: no load strobe, the block stays armed and the snapshot keeps rolling.
- R9: Writing 1 to status bit 0 or bit 1 clears that flag, and writing 0 leaves it. An alarm in the same cycle as a clear leaves the flag set.
- R10: A restore write and an alarm in the same frozen cycle perform the restore (load strobe, back to armed) and set the double-fault flag, with no trap request.
- R11: The trap request rises only after an alarm while armed, and the load strobe rises only after a restore while frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_pc_i | input | PC_W | Live program counter |
| core_psr_i | input | PSR_W | Live processor status word |
| core_stg_old_i | input | STG_W | Word in the older of the last two pipeline stages |
| core_stg_new_i | input | STG_W | Word in the newer of the last two pipeline stages |
| alarm_i | input | 1 | Fault detector alarm |
| trap_req_o | output | 1 | One-cycle trap request |
| trap_vec_o | output | VEC_W | Trap vector index |
| ld_strobe_o | output | 1 | One-cycle restore strobe to the core |
| ld_pc_o | output | PC_W | Program counter to restore |
| ld_psr_o | output | PSR_W | Status word to restore |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational) |

## Verification
Two pairs of functions can fall in the same cycle. An alarm can coincide with the handler's write-one-to-clear of the flags. A second alarm can coincide with a restore command. The bench freezes the block and then, in one cycle, raises the alarm together with a status write of 3. It judges through the register port that both flags remain set. In a later frozen cycle it raises the alarm together with a restore write. It expects the load strobe with the frozen PC and status word, the block armed again, the double-fault flag set and no trap request. Around these cases, a sweep over alarm offsets and hold lengths compares every snapshot field against values the bench computes from its own cycle counter.

// File: rtl/fault_ckpt_pkg.sv
package fault_ckpt_pkg;

  typedef enum logic {
    ST_ARMED  = 1'b0,
    ST_FROZEN = 1'b1
  } ckpt_state_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD     = 3'd1;
  localparam logic [ADDR_W-1:0] A_PC      = 3'd2;
  localparam logic [ADDR_W-1:0] A_PSR     = 3'd3;
  localparam logic [ADDR_W-1:0] A_STG_OLD = 3'd4;
  localparam logic [ADDR_W-1:0] A_STG_NEW = 3'd5;

  localparam int B_ALARM   = 0;
  localparam int B_DOUBLE  = 1;
  localparam int B_FROZEN  = 2;
  localparam int B_RESTORE = 0;
  localparam int B_RELEASE = 1;

  // sticky flag update: a new event wins over a clear in the same cycle
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/ckpt_shadow.sv
module ckpt_shadow #(
  parameter int W   = 112,
  parameter int LAG = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [LAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stg[0] <= '0;
    else if (shift_en) stg[0] <= d;
  end

  for (genvar i = 1; i < LAG; i++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stg[i] <= '0;
      else if (shift_en) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[LAG-1];
endmodule

// File: rtl/ckpt_fsm.sv
module ckpt_fsm
  import fault_ckpt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic alarm,
  input  logic restore_cmd,
  input  logic release_cmd,
  output logic frozen,
  output logic shift_en,
  output logic arm_fire,
  output logic restore_fire,
  output logic double_set,
  output logic trap_req,
  output logic ld_strobe
);
  ckpt_state_e state_q, state_d;
  logic release_fire;

  assign frozen       = (state_q == ST_FROZEN);
  assign arm_fire     = !frozen && alarm;
  assign double_set   = frozen && alarm;
  assign restore_fire = frozen && restore_cmd;
  assign release_fire = frozen && release_cmd && !restore_cmd;
  assign shift_en     = !frozen && !alarm;

  always_comb begin
    state_d = state_q;
    if (arm_fire)                          state_d = ST_FROZEN;
    else if (restore_fire || release_fire) state_d = ST_ARMED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_ARMED;
      trap_req  <= 1'b0;
      ld_strobe <= 1'b0;
    end else begin
      state_q   <= state_d;
      trap_req  <= arm_fire;
      ld_strobe <= restore_fire;
    end
  end
endmodule

// File: rtl/ckpt_regport.sv
module ckpt_regport
  import fault_ckpt_pkg::*;
#(
  parameter int DW    = 32,
  parameter int PC_W  = 32,
  parameter int PSR_W = 16,
  parameter int STG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              alarm,
  input  logic              double_set,
  input  logic              frozen,
  input  logic [PC_W-1:0]   snap_pc,
  input  logic [PSR_W-1:0]  snap_psr,
  input  logic [STG_W-1:0]  snap_old,
  input  logic [STG_W-1:0]  snap_new,
  output logic              restore_cmd,
  output logic              release_cmd,
  output logic              alarm_flag,
  output logic              double_flag
);
  logic wr_status, wr_cmd;
  logic unused_wdata_hi;

  assign wr_status   = wr && (addr == A_STATUS);
  assign wr_cmd      = wr && (addr == A_CMD);
  assign restore_cmd = wr_cmd && wdata[B_RESTORE];
  assign release_cmd = wr_cmd && wdata[B_RELEASE];
  assign unused_wdata_hi = ^wdata[DW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_flag  <= 1'b0;
      double_flag <= 1'b0;
    end else begin
      alarm_flag  <= sticky_next(alarm_flag, alarm, wr_status && wdata[B_ALARM]);
      double_flag <= sticky_next(double_flag, double_set, wr_status && wdata[B_DOUBLE]);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STATUS: begin
        rdata[B_ALARM]  = alarm_flag;
        rdata[B_DOUBLE] = double_flag;
        rdata[B_FROZEN] = frozen;
      end
      A_PC:      rdata = DW'(snap_pc);
      A_PSR:     rdata = DW'(snap_psr);
      A_STG_OLD: rdata = DW'(snap_old);
      A_STG_NEW: rdata = DW'(snap_new);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/fault_ckpt_ctrl.sv
module fault_ckpt_ctrl
  import fault_ckpt_pkg::*;
#(
  parameter int               PC_W     = 32,
  parameter int               PSR_W    = 16,
  parameter int               STG_W    = 32,
  parameter int               DW       = 32,
  parameter int               LAG      = 2,
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] TRAP_VEC = 8'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   core_pc_i,
  input  logic [PSR_W-1:0]  core_psr_i,
  input  logic [STG_W-1:0]  core_stg_old_i,
  input  logic [STG_W-1:0]  core_stg_new_i,
  input  logic              alarm_i,
  output logic              trap_req_o,
  output logic [VEC_W-1:0]  trap_vec_o,
  output logic              ld_strobe_o,
  output logic [PC_W-1:0]   ld_pc_o,
  output logic [PSR_W-1:0]  ld_psr_o,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o
);
  localparam int SNAP_W = PC_W + PSR_W + 2 * STG_W;

  logic              frozen, shift_en, arm_fire, restore_fire, double_set;
  logic              restore_cmd, release_cmd, alarm_flag, double_flag;
  logic [SNAP_W-1:0] live, snap;
  logic [PC_W-1:0]   snap_pc;
  logic [PSR_W-1:0]  snap_psr;
  logic [STG_W-1:0]  snap_old, snap_new;

  assign live = {core_pc_i, core_psr_i, core_stg_old_i, core_stg_new_i};
  assign {snap_pc, snap_psr, snap_old, snap_new} = snap;
  assign trap_vec_o = TRAP_VEC;

  ckpt_shadow #(.W(SNAP_W), .LAG(LAG)) u_shadow (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .d(live), .q(snap)
  );

  ckpt_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .alarm(alarm_i),
    .restore_cmd(restore_cmd), .release_cmd(release_cmd),
    .frozen(frozen), .shift_en(shift_en), .arm_fire(arm_fire),
    .restore_fire(restore_fire), .double_set(double_set),
    .trap_req(trap_req_o), .ld_strobe(ld_strobe_o)
  );

  ckpt_regport #(.DW(DW), .PC_W(PC_W), .PSR_W(PSR_W), .STG_W(STG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .rdata(reg_rdata_o), .alarm(alarm_i),
    .double_set(double_set), .frozen(frozen), .snap_pc(snap_pc),
    .snap_psr(snap_psr), .snap_old(snap_old), .snap_new(snap_new),
    .restore_cmd(restore_cmd), .release_cmd(release_cmd),
    .alarm_flag(alarm_flag), .double_flag(double_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_pc_o  <= '0;
      ld_psr_o <= '0;
    end else if (restore_fire) begin
      ld_pc_o  <= snap_pc;
      ld_psr_o <= snap_psr;
    end
  end
endmodule

// File: rtl/fault_ckpt_chk.sv
module fault_ckpt_chk #(
  parameter int SNAP_W = 112
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alarm_i,
  input logic              frozen,
  input logic              trap_req,
  input logic              ld_strobe,
  input logic              arm_fire,
  input logic              restore_fire,
  input logic              alarm_flag,
  input logic              double_flag,
  input logic [SNAP_W-1:0] snap
);
  assert_trap_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_fire |=> (trap_req && frozen));

  assert_trap_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req);

  assert_snap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(snap));

  assert_double_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_i && frozen) |=> (double_flag && !trap_req));

  assert_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restore_fire |=> (ld_strobe && !frozen));

  assert_alarm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_i |=> alarm_flag);

  assert_trap_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(arm_fire));

  assert_ld_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_strobe |-> $past(restore_fire));
endmodule

bind fault_ckpt_ctrl fault_ckpt_chk #(.SNAP_W(SNAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alarm_i(alarm_i), .frozen(frozen),
  .trap_req(trap_req_o), .ld_strobe(ld_strobe_o), .arm_fire(arm_fire),
  .restore_fire(restore_fire), .alarm_flag(alarm_flag),
  .double_flag(double_flag), .snap(snap)
);

// File: tb/fault_ckpt_ctrl_test.sv
`timescale 1ns/1ps
module fault_ckpt_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] core_pc = '0;
  logic [15:0] core_psr = '0;
  logic [31:0] core_old = '0, core_new = '0;
  logic        alarm = 1'b0;
  logic        trap_req, ld_strobe;
  logic [7:0]  trap_vec;
  logic [31:0] ld_pc;
  logic [15:0] ld_psr;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  int k = 0;
  int nchk = 0, nfail = 0;

  fault_ckpt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .core_pc_i(core_pc), .core_psr_i(core_psr),
    .core_stg_old_i(core_old), .core_stg_new_i(core_new), .alarm_i(alarm),
    .trap_req_o(trap_req), .trap_vec_o(trap_vec), .ld_strobe_o(ld_strobe),
    .ld_pc_o(ld_pc), .ld_psr_o(ld_psr), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] fpc(int m);  return 32'h0000_4000 + 32'(m) * 4;            endfunction
  function automatic logic [15:0] fpsr(int m); return 16'(m * 37) ^ 16'h5A5A;               endfunction
  function automatic logic [31:0] fold(int m); return (32'(m) * 32'h0101_0101) ^ 32'hC0DE_0000; endfunction
  function automatic logic [31:0] fnew(int m); return ~(32'(m) * 13);                        endfunction

  // core inputs change just after each rising edge; cycle k carries f(k)
  always @(posedge clk) begin
    #1;
    k = k + 1;
    core_pc = fpc(k); core_psr = fpsr(k); core_old = fold(k); core_new = fnew(k);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_status(input string req, input logic [31:0] exp);
    logic [31:0] d;
    rd(3'd0, d);
    chk(req, d, exp);
  endtask

  task automatic chk_snap(input string req, input int m);
    logic [31:0] d;
    rd(3'd2, d); chk(req, d, fpc(m));
    rd(3'd3, d); chk(req, d, {16'h0, fpsr(m)});
    rd(3'd4, d); chk(req, d, fold(m));
    rd(3'd5, d); chk(req, d, fnew(m));
  endtask

  task automatic chk_zero_snap(input string req);
    logic [31:0] d;
    for (int a = 2; a < 6; a++) begin
      rd(3'(a), d);
      chk(req, d, 32'h0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=done", k);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    int a;
    repeat (4) tick();
    chk("R1 trap in reset", {31'h0, trap_req}, 32'h0);
    chk("R1 ld in reset", {31'h0, ld_strobe}, 32'h0);
    rst_n = 1'b1;
    chk_status("R1 status", 32'h0);
    chk_zero_snap("R1 snapshot");

    repeat (3) tick();
    for (int n = 0; n < 40; n++) begin
      tick();
      chk_snap("R2 rolling", k - 2);
      chk("R11 no trap", {31'h0, trap_req}, 32'h0);
      chk("R11 no ld", {31'h0, ld_strobe}, 32'h0);
    end

    // R8: commands while armed
    wr(3'd1, 32'h1);
    chk("R8 no ld", {31'h0, ld_strobe}, 32'h0);
    chk_status("R8 armed", 32'h0);
    wr(3'd1, 32'h2);
    chk_status("R8 armed", 32'h0);
    tick();
    chk_snap("R8 rolling", k - 2);

    for (int i = 0; i < 6; i++) begin
      repeat (i + 1) tick();
      a = k;
      alarm = 1'b1;
      tick();
      alarm = 1'b0;
      chk("R3 trap", {31'h0, trap_req}, 32'h1);
      chk("R3 vec", {24'h0, trap_vec}, 32'h2A);
      chk_status("R3 status", 32'h5);
      tick();
      chk("R3 single", {31'h0, trap_req}, 32'h0);
      repeat (2 + i) tick();
      chk_snap("R4 frozen", a - 2);
      if (i % 2 == 0) begin
        alarm = 1'b1;
        tick();
        alarm = 1'b0;
        chk("R5 no trap", {31'h0, trap_req}, 32'h0);
        tick();
        chk_status("R5 double", 32'h7);
        chk_snap("R5 snapshot", a - 2);
      end
      if (i % 3 != 2) begin
        wr(3'd1, 32'h1);
        chk("R6 ld", {31'h0, ld_strobe}, 32'h1);
        chk("R6 pc", ld_pc, fpc(a - 2));
        chk("R6 psr", {16'h0, ld_psr}, {16'h0, fpsr(a - 2)});
        chk_status("R6 armed", (i % 2 == 0) ? 32'h3 : 32'h1);
      end else begin
        wr(3'd1, 32'h2);
        chk("R7 no ld", {31'h0, ld_strobe}, 32'h0);
        chk_status("R7 armed", (i % 2 == 0) ? 32'h3 : 32'h1);
      end
      tick();
      chk("R6 single ld", {31'h0, ld_strobe}, 32'h0);
      wr(3'd0, 32'h1);
      chk_status("R9 clear alarm", (i % 2 == 0) ? 32'h2 : 32'h0);
      wr(3'd0, 32'h2);
      chk_status("R9 clear double", 32'h0);
      repeat (2) tick();
      chk_snap("R2 resumed", k - 2);
    end

    // alarm meets write-one-to-clear
    tick();
    a = k;
    alarm = 1'b1;
    tick();
    alarm = 1'b0;
    alarm = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h3;
    tick();
    alarm = 1'b0; reg_wr = 1'b0;
    chk_status("R9 set wins", 32'h7);
    chk("R5 no trap", {31'h0, trap_req}, 32'h0);
    wr(3'd0, 32'h3);
    chk_status("R9 cleared", 32'h4);

    // alarm meets restore
    alarm = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h1;
    tick();
    alarm = 1'b0; reg_wr = 1'b0;
    chk("R10 ld", {31'h0, ld_strobe}, 32'h1);
    chk("R10 pc", ld_pc, fpc(a - 2));
    chk("R10 no trap", {31'h0, trap_req}, 32'h0);
    chk_status("R10 status", 32'h3);
    tick();
    chk("R10 ld single", {31'h0, ld_strobe}, 32'h0);
    chk("R10 trap", {31'h0, trap_req}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule